// File: doc/BRIEF.md
# Masked Vector Integer ALU with Reductions

This block is the integer execute stage for a small vector extension. Each cycle it can take one operation with up to three vector sources, a scalar operand, a mask vector, a two-bit mask mode and an active vector length. One cycle later it returns the new destination vector. The caller supplies the current destination contents on `dst_old`. Any element the operation does not write comes back unchanged, so the result can go straight back into a register file.

The operations are:
- element-wise add, multiply, multiply-add, signed maximum and signed minimum;
- splat, which copies one element of the first source to every element;
- broadcast of the scalar operand;
- sum, minimum and maximum reductions, which fold the selected elements of the first source into one value and write it to every enabled destination element.

The mask mode picks one of four write patterns: a scalar-shaped result in element 0 only, every active element, elements whose mask element has least significant bit 0, or elements whose mask element has least significant bit 1.

Top module: `vec_alu_unit`

## Requirements
- R1: While `rst` is high and after it falls, `out_valid` is 0 and `dst_new` is all zeros until the first accepted operation.
- R2: An operation presented with `in_valid` high at a rising edge produces `dst_new` with `out_valid` high after the next rising edge. `out_valid` is low in a cycle that follows an idle cycle. Operations may be issued back to back, one per cycle.
- R3: `op_code` 0 is add (a+b), 1 is multiply (low 32 bits of a*b) and 2 is multiply-add (low 32 bits of a*b, plus c). All are computed per element and wrap modulo 2^32.
- R4: `op_code` 3 is element-wise maximum and 4 is element-wise minimum of a and b, both under two's-complement signed comparison.
- R5: With `mask_mode` 00, only element 0 may be written, and only when the effective vector length is at least 1. Every other element returns its `dst_old` value.
- R6: With `mask_mode` 01, every element whose index is below the effective vector length is written.
- R7: With `mask_mode` 10, an element below the effective length is written only if bit 0 of its `mask_vec` element is 0. Otherwise it keeps `dst_old`.
- R8: With `mask_mode` 11, an element below the effective length is written only if bit 0 of its `mask_vec` element is 1. Otherwise it keeps `dst_old`.
- R9: The effective vector length is `vec_len` clamped to the lane count (4). Elements at or above it always return their `dst_old` value.
- R10: `op_code` 5 (splat) writes element a[`scalar_in`] to every enabled element. It writes zero instead when `scalar_in` is not below the effective vector length.
- R11: `op_code` 6 (broadcast) writes `scalar_in` to every enabled element.
- R12: `op_code` 7 (sum), 8 (signed minimum) and 9 (signed maximum) fold the elements of a that lie below the effective length and pass the mask test of R7/R8 when that mode is in force. The single result is written to every enabled element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select (see R3, R4, R10 to R12) |
| mask_mode | input | 2 | Write pattern select (see R5 to R8) |
| vec_len | input | 3 | Requested active vector length |
| src_a | input | 128 | First vector source, element i at bits 32i+31:32i |
| src_b | input | 128 | Second vector source |
| src_c | input | 128 | Third vector source (multiply-add addend) |
| scalar_in | input | 32 | Scalar operand or splat index |
| mask_vec | input | 128 | Mask vector; bit 0 of each element is tested |
| dst_old | input | 128 | Current destination contents |
| out_valid | output | 1 | `dst_new` carries a result |
| dst_new | output | 128 | New destination contents |

## Verification
The bench builds the unit with its defaults: four lanes of 32 bits and a three-bit length input. That width lets `vec_len` go up to 7, so requests above the lane count exercise the clamp of R9. The 32-bit element width makes product wrap-around and signed-versus-unsigned ordering observable with ordinary operand values. Four lanes also keep every mask pattern, and every splat index both inside and outside the active length, within a short directed sequence that a scoreboard compares against an independent model.

// File: rtl/vec_alu_pkg.sv
package vec_alu_pkg;

    localparam int DEF_LANES  = 4;
    localparam int DEF_ELEM_W = 32;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_MUL   = 4'd1,
        OP_MADD  = 4'd2,
        OP_MAX   = 4'd3,
        OP_MIN   = 4'd4,
        OP_SPLAT = 4'd5,
        OP_BCAST = 4'd6,
        OP_RSUM  = 4'd7,
        OP_RMIN  = 4'd8,
        OP_RMAX  = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        MM_SCALAR = 2'b00,
        MM_ALL    = 2'b01,
        MM_ZERO   = 2'b10,
        MM_ONE    = 2'b11
    } mmode_e;

    typedef enum logic [1:0] {
        RED_SUM = 2'd0,
        RED_MIN = 2'd1,
        RED_MAX = 2'd2
    } red_e;

    typedef struct packed {
        op_e    op;
        mmode_e mode;
        logic   is_red;
        red_e   red;
        logic   is_splat;
    } decode_t;

    function automatic logic op_is_reduction(op_e op);
        return (op == OP_RSUM) || (op == OP_RMIN) || (op == OP_RMAX);
    endfunction

    function automatic red_e op_red_kind(op_e op);
        case (op)
            OP_RMIN: return RED_MIN;
            OP_RMAX: return RED_MAX;
            default: return RED_SUM;
        endcase
    endfunction

    function automatic decode_t decode_op(logic [3:0] code, logic [1:0] mm);
        decode_t d;
        d.op       = op_e'(code);
        d.mode     = mmode_e'(mm);
        d.is_red   = op_is_reduction(op_e'(code));
        d.red      = op_red_kind(op_e'(code));
        d.is_splat = (op_e'(code) == OP_SPLAT);
        return d;
    endfunction

endpackage

// File: rtl/vec_write_enable.sv
module vec_write_enable
    import vec_alu_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int ELEM_W = DEF_ELEM_W,
    localparam int VL_W  = $clog2(LANES + 1)
) (
    input  mmode_e                    mode,
    input  logic [VL_W-1:0]           vl_req,
    input  logic [LANES*ELEM_W-1:0]   mask_vec,
    output logic [VL_W-1:0]           vl_eff,
    output logic [LANES-1:0]          red_sel,
    output logic [LANES-1:0]          wr_en
);

    always_comb begin
        if (int'(vl_req) > LANES) vl_eff = VL_W'(LANES);
        else                      vl_eff = vl_req;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic active;
        logic mbit;
        logic pass;

        assign active = (VL_W'(i) < vl_eff);
        assign mbit   = mask_vec[i*ELEM_W];

        always_comb begin
            case (mode)
                MM_ZERO: pass = ~mbit;
                MM_ONE:  pass = mbit;
                default: pass = 1'b1;
            endcase
        end

        assign red_sel[i] = active && pass;

        if (i == 0) begin : g_first
            assign wr_en[i] = active && pass;
        end else begin : g_rest
            assign wr_en[i] = active && pass && (mode != MM_SCALAR);
        end
    end

endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
    import vec_alu_pkg::*;
#(
    parameter int ELEM_W = DEF_ELEM_W
) (
    input  op_e               op,
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    input  logic [ELEM_W-1:0] c,
    input  logic [ELEM_W-1:0] scalar,
    output logic [ELEM_W-1:0] y
);

    logic [ELEM_W-1:0] prod_lo;
    logic              a_gt_b;

    assign prod_lo = a * b;
    assign a_gt_b  = ($signed(a) > $signed(b));

    always_comb begin
        case (op)
            OP_ADD:   y = a + b;
            OP_MUL:   y = prod_lo;
            OP_MADD:  y = prod_lo + c;
            OP_MAX:   y = a_gt_b ? a : b;
            OP_MIN:   y = a_gt_b ? b : a;
            OP_BCAST: y = scalar;
            default:  y = a;
        endcase
    end

endmodule

// File: rtl/vec_reduce.sv
module vec_reduce
    import vec_alu_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int ELEM_W = DEF_ELEM_W
) (
    input  red_e                      kind,
    input  logic [LANES*ELEM_W-1:0]   src,
    input  logic [LANES-1:0]          sel,
    output logic [ELEM_W-1:0]         result
);

    localparam logic [ELEM_W-1:0] POS_MAX = {1'b0, {(ELEM_W-1){1'b1}}};
    localparam logic [ELEM_W-1:0] NEG_MIN = {1'b1, {(ELEM_W-1){1'b0}}};

    logic [ELEM_W-1:0] chain [LANES+1];

    always_comb begin
        case (kind)
            RED_MIN: chain[0] = POS_MAX;
            RED_MAX: chain[0] = NEG_MIN;
            default: chain[0] = '0;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_fold
        logic [ELEM_W-1:0] e;
        logic [ELEM_W-1:0] comb_v;
        assign e = src[i*ELEM_W +: ELEM_W];

        always_comb begin
            case (kind)
                RED_MIN: comb_v = ($signed(e) < $signed(chain[i])) ? e : chain[i];
                RED_MAX: comb_v = ($signed(e) > $signed(chain[i])) ? e : chain[i];
                default: comb_v = chain[i] + e;
            endcase
        end

        assign chain[i+1] = sel[i] ? comb_v : chain[i];
    end

    assign result = chain[LANES];

endmodule

// File: rtl/vec_alu_unit.sv
module vec_alu_unit
    import vec_alu_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int ELEM_W = DEF_ELEM_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [3:0]                    op_code,
    input  logic [1:0]                    mask_mode,
    input  logic [$clog2(LANES+1)-1:0]    vec_len,
    input  logic [LANES*ELEM_W-1:0]       src_a,
    input  logic [LANES*ELEM_W-1:0]       src_b,
    input  logic [LANES*ELEM_W-1:0]       src_c,
    input  logic [ELEM_W-1:0]             scalar_in,
    input  logic [LANES*ELEM_W-1:0]       mask_vec,
    input  logic [LANES*ELEM_W-1:0]       dst_old,
    output logic                          out_valid,
    output logic [LANES*ELEM_W-1:0]       dst_new
);

    localparam int VL_W  = $clog2(LANES + 1);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    decode_t                  dec;
    logic [VL_W-1:0]          vl_eff;
    logic [LANES-1:0]         red_sel;
    logic [LANES-1:0]         wr_en;
    logic [ELEM_W-1:0]        red_val;
    logic [ELEM_W-1:0]        splat_val;
    logic [LANES*ELEM_W-1:0]  lane_val;
    logic [LANES*ELEM_W-1:0]  next_dst;

    assign dec = decode_op(op_code, mask_mode);

    vec_write_enable #(.LANES(LANES), .ELEM_W(ELEM_W)) u_wen (
        .mode     (dec.mode),
        .vl_req   (vec_len),
        .mask_vec (mask_vec),
        .vl_eff   (vl_eff),
        .red_sel  (red_sel),
        .wr_en    (wr_en)
    );

    vec_reduce #(.LANES(LANES), .ELEM_W(ELEM_W)) u_red (
        .kind   (dec.red),
        .src    (src_a),
        .sel    (red_sel),
        .result (red_val)
    );

    always_comb begin
        if (scalar_in < ELEM_W'(vl_eff))
            splat_val = src_a[scalar_in[IDX_W-1:0]*ELEM_W +: ELEM_W];
        else
            splat_val = '0;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ELEM_W-1:0] alu_y;
        logic [ELEM_W-1:0] pick;

        vec_lane_alu #(.ELEM_W(ELEM_W)) u_alu (
            .op     (dec.op),
            .a      (src_a[i*ELEM_W +: ELEM_W]),
            .b      (src_b[i*ELEM_W +: ELEM_W]),
            .c      (src_c[i*ELEM_W +: ELEM_W]),
            .scalar (scalar_in),
            .y      (alu_y)
        );

        always_comb begin
            if (dec.is_red)        pick = red_val;
            else if (dec.is_splat) pick = splat_val;
            else                   pick = alu_y;
        end

        assign lane_val[i*ELEM_W +: ELEM_W] = pick;
        assign next_dst[i*ELEM_W +: ELEM_W] =
            wr_en[i] ? pick : dst_old[i*ELEM_W +: ELEM_W];

        // R9: lanes at or above the requested length are untouched
        assert_tail_keep_R9: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (int'(vec_len) <= i))
            |=> (dst_new[i*ELEM_W +: ELEM_W] == $past(dst_old[i*ELEM_W +: ELEM_W])));

        if (i > 0) begin : g_upper
            // R5: scalar-shaped mode leaves upper lanes alone
            assert_scalar_shape_R5: assert property (@(posedge clk) disable iff (rst)
                (in_valid && (mask_mode == 2'b00))
                |=> (dst_new[i*ELEM_W +: ELEM_W] == $past(dst_old[i*ELEM_W +: ELEM_W])));

            // R12: full-length unmasked reduction gives equal lanes
            assert_red_bcast_R12: assert property (@(posedge clk) disable iff (rst)
                (in_valid && (op_code >= 4'd7) && (op_code <= 4'd9)
                 && (mask_mode == 2'b01) && (int'(vec_len) >= LANES))
                |=> (dst_new[i*ELEM_W +: ELEM_W] == dst_new[ELEM_W-1:0]));
        end

        // R7: mode 10 skips lanes whose mask bit 0 is set
        assert_mask_zero_R7: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (mask_mode == 2'b10) && mask_vec[i*ELEM_W])
            |=> (dst_new[i*ELEM_W +: ELEM_W] == $past(dst_old[i*ELEM_W +: ELEM_W])));

        // R8: mode 11 skips lanes whose mask bit 0 is clear
        assert_mask_one_R8: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (mask_mode == 2'b11) && !mask_vec[i*ELEM_W])
            |=> (dst_new[i*ELEM_W +: ELEM_W] == $past(dst_old[i*ELEM_W +: ELEM_W])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dst_new   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) dst_new <= next_dst;
        end
    end

    // R2: one-cycle result latency
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2: result holds while idle
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(dst_new));

endmodule

// File: tb/vec_alu_unit_test.sv
module vec_alu_unit_test;

    localparam int N  = 4;
    localparam int W  = 32;
    localparam int VW = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [3:0]     op_code = '0;
    logic [1:0]     mask_mode = '0;
    logic [VW-1:0]  vec_len = '0;
    logic [N*W-1:0] src_a = '0, src_b = '0, src_c = '0, mask_vec = '0, dst_old = '0;
    logic [W-1:0]   scalar_in = '0;
    logic           out_valid;
    logic [N*W-1:0] dst_new;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [N*W-1:0] exp_q[$];
    string          tag_q[$];

    always #2 clk = ~clk;

    vec_alu_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .mask_mode(mask_mode), .vec_len(vec_len), .src_a(src_a), .src_b(src_b),
        .src_c(src_c), .scalar_in(scalar_in), .mask_vec(mask_vec),
        .dst_old(dst_old), .out_valid(out_valid), .dst_new(dst_new)
    );

    function automatic logic [N*W-1:0] pk(logic [W-1:0] e0, logic [W-1:0] e1,
                                         logic [W-1:0] e2, logic [W-1:0] e3);
        return {e3, e2, e1, e0};
    endfunction

    function automatic logic [N*W-1:0] model(
        int op, int mm, int vl,
        logic [N*W-1:0] a, logic [N*W-1:0] b, logic [N*W-1:0] c,
        logic [W-1:0] s, logic [N*W-1:0] m, logic [N*W-1:0] old);
        logic [N*W-1:0] r;
        logic [W-1:0]   acc, ea, eb, ec, v;
        logic [63:0]    p;
        bit             sel [N];
        bit             wen [N];
        int             ve;
        ve = (vl > N) ? N : vl;
        for (int i = 0; i < N; i++) begin
            bit lsb;
            lsb = m[i*W];
            sel[i] = (i < ve) && ((mm == 2) ? !lsb : (mm == 3) ? lsb : 1'b1);
            wen[i] = (mm == 0) ? ((i == 0) && (ve > 0)) : sel[i];
        end
        acc = (op == 8) ? 32'h7fff_ffff : (op == 9) ? 32'h8000_0000 : 32'h0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) begin
                ea = a[i*W +: W];
                if (op == 7) acc = acc + ea;
                else if (op == 8 && $signed(ea) < $signed(acc)) acc = ea;
                else if (op == 9 && $signed(ea) > $signed(acc)) acc = ea;
            end
        end
        r = old;
        for (int i = 0; i < N; i++) begin
            ea = a[i*W +: W]; eb = b[i*W +: W]; ec = c[i*W +: W];
            p = {32'h0, ea} * {32'h0, eb};
            case (op)
                0: v = ea + eb;
                1: v = p[31:0];
                2: v = p[31:0] + ec;
                3: v = ($signed(ea) >= $signed(eb)) ? ea : eb;
                4: v = ($signed(ea) <= $signed(eb)) ? ea : eb;
                5: v = (s < ve) ? a[s*W +: W] : 32'h0;
                6: v = s;
                default: v = acc;
            endcase
            if (wen[i]) r[i*W +: W] = v;
        end
        return r;
    endfunction

    task automatic send(int op, int mm, int vl,
                        logic [N*W-1:0] a, logic [N*W-1:0] b, logic [N*W-1:0] c,
                        logic [W-1:0] s, logic [N*W-1:0] m, logic [N*W-1:0] old,
                        string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        op_code   = 4'(op);
        mask_mode = 2'(mm);
        vec_len   = VW'(vl);
        src_a = a; src_b = b; src_c = c; scalar_in = s; mask_vec = m; dst_old = old;
        exp_q.push_back(model(op, mm, vl, a, b, c, s, m, old));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check(bit ok, string tag, logic [N*W-1:0] act, logic [N*W-1:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid", dst_new, '0);
                end else begin
                    logic [N*W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(dst_new === e, t, dst_new, e);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] A, B, C, OLD, MSK;
        A   = pk(32'd7, 32'hffff_fffe, 32'h8000_0001, 32'd100);
        B   = pk(32'd5, 32'd3, 32'h7fff_ffff, 32'h0001_0000);
        C   = pk(32'd1, 32'd2, 32'd3, 32'd4);
        OLD = pk(32'hdead_0000, 32'hdead_0001, 32'hdead_0002, 32'hdead_0003);
        MSK = pk(32'h2, 32'h1, 32'h4, 32'h3);

        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && dst_new == '0, "R1 during reset", dst_new, '0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && dst_new == '0, "R1 after reset", dst_new, '0);

        send(0, 1, 4, A, B, C, 0, MSK, OLD, "R3 add");
        send(1, 1, 4, A, pk(32'h0001_0000, 32'h0001_0000, 32'd2, 32'h0002_0000), C, 0, MSK, OLD, "R3 mul wrap");
        send(2, 1, 4, A, B, C, 0, MSK, OLD, "R3 madd");
        send(3, 1, 4, A, B, C, 0, MSK, OLD, "R4 signed max");
        send(4, 1, 4, A, B, C, 0, MSK, OLD, "R4 signed min");
        idle(1);
        send(0, 0, 4, A, B, C, 0, MSK, OLD, "R5 scalar shape");
        send(6, 0, 0, A, B, C, 32'h55, MSK, OLD, "R5 scalar shape vl0");
        send(0, 1, 3, A, B, C, 0, MSK, OLD, "R6 unmasked vl3");
        send(0, 2, 4, A, B, C, 0, MSK, OLD, "R7 mask lsb0");
        send(0, 3, 4, A, B, C, 0, MSK, OLD, "R8 mask lsb1");
        send(6, 3, 3, A, B, C, 32'h1234_5678, MSK, OLD, "R8 bcast masked");
        send(0, 1, 2, A, B, C, 0, MSK, OLD, "R9 tail keep vl2");
        send(0, 1, 7, A, B, C, 0, MSK, OLD, "R9 clamp vl7");
        send(0, 1, 0, A, B, C, 0, MSK, OLD, "R9 vl0 no write");
        send(5, 1, 4, A, B, C, 32'd2, MSK, OLD, "R10 splat idx2");
        send(5, 1, 3, A, B, C, 32'd3, MSK, OLD, "R10 splat idx beyond vl");
        send(5, 1, 6, A, B, C, 32'd3, MSK, OLD, "R10 splat idx3 clamped vl");
        send(6, 1, 4, A, B, C, 32'hcafe_f00d, MSK, OLD, "R11 broadcast");
        send(7, 1, 4, A, B, C, 0, MSK, OLD, "R12 sum all");
        send(8, 2, 4, A, B, C, 0, MSK, OLD, "R12 min mask lsb0");
        send(9, 3, 3, A, B, C, 0, MSK, OLD, "R12 max mask lsb1 vl3");
        send(7, 0, 3, A, B, C, 0, MSK, OLD, "R12 sum scalar shape");
        send(9, 1, 2, A, B, C, 0, MSK, OLD, "R12 max vl2");
        idle(3);
        check(exp_q.size() == 0, "R2 all results returned", exp_q.size(), 0);
        check(out_valid == 1'b0, "R2 idle out_valid low", out_valid, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule